// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Controller

This block performs bank switching for a cartridge on an 8-bit CPU bus. The CPU cannot write a whole register in one store. It delivers a value one bit per write into a five-stage shift register. The fifth write commits the assembled value to one of four internal registers: control, low character bank, high character bank or program bank. The upper CPU window address of that fifth write picks the register. A write with data bit 7 set abandons any partial value. The same write also forces the program mode to its reset setting.

From these registers the block forms two translated addresses. For the CPU it produces a program-memory address that covers 16 KB or 32 KB windows. For the picture side it produces a character-memory address that covers 4 KB or 8 KB windows. It also outputs the 2-bit nametable mirroring code held in the control register. Both translated addresses are combinational from the current register contents. A committed value first shows up on the outputs after the clock edge that ends the fifth write.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the control register holds 0x1C and all bank registers and the shifter are zero. Mirroring is therefore 0. The CPU window at offsets 0x4000 and above maps to bank PRG_BANKS-1, and the lower window maps to bank 0.
- R2: A write with data bit 7 set empties the shifter and the write count. It sets control bits 3:2 to 1 and keeps the other control bits. It commits nothing, even when four bits are already pending.
- R3: A write with bit 7 clear shifts the value right and inserts data bit 0 at bit 4, so the value is built LSB first. Data bits 6:1 are ignored. The address on the first four writes is ignored.
- R4: On the fifth write, address bits 14:13 pick the destination: 0 control, 1 low CHR bank, 2 high CHR bank, 3 PRG bank (which keeps bits 3:0 of the value). The shifter then restarts from an empty count.
- R5: The mirroring output equals control bits 1:0. The codes are 0 one-screen lower, 1 one-screen upper, 2 vertical, 3 horizontal.
- R6: With control bits 3:2 at 0 or 1, the program address is {prg[3:1], cpu_addr[14:0]}. This is a 32 KB window that ignores the bank's bit 0.
- R7: With control bits 3:2 equal to 2, offsets below 0x4000 map to bank 0 and offsets from 0x4000 up map to the PRG bank register. The offset within the bank is cpu_addr[13:0].
- R8: With control bits 3:2 equal to 3, offsets below 0x4000 map to the PRG bank register and offsets from 0x4000 up map to bank PRG_BANKS-1.
- R9: With control bit 4 set, picture addresses below 0x1000 map to {chr_lo, ppu_addr[11:0]} and higher addresses map to {chr_hi, ppu_addr[11:0]}.
- R10: With control bit 4 clear, the character address is {chr_lo[4:1], ppu_addr[12:0]}. This is one 8 KB window that ignores chr_lo bit 0 and the high bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | Single-cycle CPU write strobe into the bank window |
| cpu_addr | input | 15 | CPU offset inside the 32 KB window, used for decode and translation |
| cpu_wr_data | input | 8 | CPU write data; bit 7 is the restart bit, bit 0 is the serial bit |
| ppu_addr | input | 13 | Picture-side address inside the 8 KB character space |
| prg_addr | output | 18 | Translated program-memory byte address |
| chr_addr | output | 17 | Translated character-memory byte address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The restart bit and the fifth-write commit can fall in the same cycle. A write with bit 7 set can arrive when four bits are already pending and its address selects a register. The bench provokes this on purpose and also during random traffic. It then judges the outcome at the translation ports. Each bank mapping must be unchanged. Control bits 3:2 must be forced while the mirroring bits are kept. A following full five-write sequence must land exactly, which shows the count restarted.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int LOAD_W     = 5;
    localparam int CNT_W      = $clog2(LOAD_W);
    localparam int PRG_SEL_W  = 4;
    localparam int CHR_SEL_W  = LOAD_W;
    localparam int PRG_WIN_W  = 14;
    localparam int CHR_WIN_W  = 12;
    localparam int DATA_W     = 8;

    localparam logic [LOAD_W-1:0] CTRL_RESET = 5'h1C;
    localparam logic [LOAD_W-1:0] CTRL_FORCE = 5'b01100;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_CHR_LO = 2'd1,
        SEL_CHR_HI = 2'd2,
        SEL_PRG    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MIR_SINGLE_LO = 2'd0,
        MIR_SINGLE_HI = 2'd1,
        MIR_VERT      = 2'd2,
        MIR_HORZ      = 2'd3
    } mirror_e;

    typedef struct packed {
        logic [LOAD_W-1:0]    ctrl;
        logic [CHR_SEL_W-1:0] chr_lo;
        logic [CHR_SEL_W-1:0] chr_hi;
        logic [PRG_SEL_W-1:0] prg;
    } bank_regs_t;

    typedef struct packed {
        logic [LOAD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
    } loader_t;
endpackage

// File: rtl/sbm_serial_loader.sv
module sbm_serial_loader
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              clear_o,
    output logic              commit_o,
    output logic [LOAD_W-1:0] value_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOAD_W - 1);

    loader_t st_d, st_q;
    logic    shift_en;
    logic    unused_data;

    assign unused_data = ^wr_data_i[DATA_W-2:1];

    always_comb begin
        st_d     = st_q;
        clear_o  = wr_en_i &  wr_data_i[DATA_W-1];
        shift_en = wr_en_i & ~wr_data_i[DATA_W-1];
        value_o  = {wr_data_i[0], st_q.shift[LOAD_W-1:1]};
        commit_o = shift_en && (st_q.cnt == LAST_CNT);
        if (clear_o || commit_o) begin
            st_d = '0;
        end else if (shift_en) begin
            st_d.shift = value_o;
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: restart bit empties the shifter
    a_r2_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (st_q.shift == '0) && (st_q.cnt == '0));

    // R3: count never passes the last stage
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);

    // R3: each plain write below the last stage advances the count
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !commit_o) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R4: a commit restarts the count
    a_r4_commit_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (st_q.cnt == '0) && (st_q.shift == '0));
endmodule

// File: rtl/sbm_bank_regs.sv
module sbm_bank_regs
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              commit_i,
    input  reg_sel_e          sel_i,
    input  logic [LOAD_W-1:0] value_i,
    output bank_regs_t        regs_o
);
    bank_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.ctrl = r_q.ctrl | CTRL_FORCE;
        end else if (commit_i) begin
            unique case (sel_i)
                SEL_CTRL:   r_d.ctrl   = value_i;
                SEL_CHR_LO: r_d.chr_lo = value_i;
                SEL_CHR_HI: r_d.chr_hi = value_i;
                SEL_PRG:    r_d.prg    = value_i[PRG_SEL_W-1:0];
                default:    r_d        = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ctrl   <= CTRL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q;

    // R2: restart and commit never coincide
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && commit_i));

    // R2: restart forces the program mode and keeps mirroring
    a_r2_force_mode: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (r_q.ctrl[3:2] == 2'b11) &&
                    (r_q.ctrl[1:0] == $past(r_q.ctrl[1:0])) &&
                    (r_q.chr_lo == $past(r_q.chr_lo)) &&
                    (r_q.prg == $past(r_q.prg)));

    // R3: without restart or commit nothing moves
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !commit_i) |=> $stable(r_q));

    // R4: a commit to a bank register leaves control alone
    a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && sel_i != SEL_CTRL) |=> $stable(r_q.ctrl));
endmodule

// File: rtl/sbm_prg_map.sv
module sbm_prg_map
    import sbm_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic [1:0]                     mode_i,
    input  logic [PRG_SEL_W-1:0]           bank_i,
    input  logic [PRG_WIN_W:0]             cpu_addr_i,
    output logic [PRG_SEL_W+PRG_WIN_W-1:0] prg_addr_o
);
    localparam logic [PRG_SEL_W-1:0] LAST_BANK = PRG_SEL_W'(PRG_BANKS - 1);

    logic                 upper;
    logic [PRG_SEL_W-1:0] sel_bank;

    always_comb begin
        upper    = cpu_addr_i[PRG_WIN_W];
        sel_bank = '0;
        unique case (mode_i)
            2'b10:   sel_bank = upper ? bank_i : '0;
            2'b11:   sel_bank = upper ? LAST_BANK : bank_i;
            default: sel_bank = {bank_i[PRG_SEL_W-1:1], upper};
        endcase
        prg_addr_o = {sel_bank, cpu_addr_i[PRG_WIN_W-1:0]};
    end
endmodule

// File: rtl/sbm_chr_map.sv
module sbm_chr_map
    import sbm_pkg::*;
(
    input  logic                           split_i,
    input  logic [CHR_SEL_W-1:0]           lo_i,
    input  logic [CHR_SEL_W-1:0]           hi_i,
    input  logic [CHR_WIN_W:0]             ppu_addr_i,
    output logic [CHR_SEL_W+CHR_WIN_W-1:0] chr_addr_o
);
    logic [CHR_SEL_W-1:0] sel_bank;

    always_comb begin
        if (split_i) begin
            sel_bank = ppu_addr_i[CHR_WIN_W] ? hi_i : lo_i;
        end else begin
            sel_bank = {lo_i[CHR_SEL_W-1:1], ppu_addr_i[CHR_WIN_W]};
        end
        chr_addr_o = {sel_bank, ppu_addr_i[CHR_WIN_W-1:0]};
    end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import sbm_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cpu_wr_en,
    input  logic [PRG_WIN_W:0]             cpu_addr,
    input  logic [DATA_W-1:0]              cpu_wr_data,
    input  logic [CHR_WIN_W:0]             ppu_addr,
    output logic [PRG_SEL_W+PRG_WIN_W-1:0] prg_addr,
    output logic [CHR_SEL_W+CHR_WIN_W-1:0] chr_addr,
    output logic [1:0]                     mirror
);
    localparam logic [PRG_SEL_W-1:0] LAST_BANK = PRG_SEL_W'(PRG_BANKS - 1);

    logic              ld_clear;
    logic              ld_commit;
    logic [LOAD_W-1:0] ld_value;
    bank_regs_t        regs;

    sbm_serial_loader u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cpu_wr_en),
        .wr_data_i (cpu_wr_data),
        .clear_o   (ld_clear),
        .commit_o  (ld_commit),
        .value_o   (ld_value)
    );

    sbm_bank_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (ld_clear),
        .commit_i (ld_commit),
        .sel_i    (reg_sel_e'(cpu_addr[PRG_WIN_W:PRG_WIN_W-1])),
        .value_i  (ld_value),
        .regs_o   (regs)
    );

    sbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .mode_i     (regs.ctrl[3:2]),
        .bank_i     (regs.prg),
        .cpu_addr_i (cpu_addr),
        .prg_addr_o (prg_addr)
    );

    sbm_chr_map u_chr (
        .split_i    (regs.ctrl[4]),
        .lo_i       (regs.chr_lo),
        .hi_i       (regs.chr_hi),
        .ppu_addr_i (ppu_addr),
        .chr_addr_o (chr_addr)
    );

    assign mirror = regs.ctrl[1:0];

    // R6: in 32 KB mode the window half passes straight through
    a_r6_half_through: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[3] == 1'b0) |-> (prg_addr[PRG_WIN_W] == cpu_addr[PRG_WIN_W]));

    // R7: lower window pinned to bank zero
    a_r7_first_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[3:2] == 2'b10 && !cpu_addr[PRG_WIN_W]) |->
            (prg_addr[PRG_SEL_W+PRG_WIN_W-1:PRG_WIN_W] == '0));

    // R8: upper window pinned to the last bank
    a_r8_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[3:2] == 2'b11 && cpu_addr[PRG_WIN_W]) |->
            (prg_addr[PRG_SEL_W+PRG_WIN_W-1:PRG_WIN_W] == LAST_BANK));

    // R9: offset inside a character bank passes through
    a_r9_chr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[CHR_WIN_W-1:0] == ppu_addr[CHR_WIN_W-1:0]);

    // R10: in 8 KB mode the high half follows the picture address
    a_r10_chr_half: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.ctrl[4] |-> (chr_addr[CHR_WIN_W] == ppu_addr[CHR_WIN_W]));
endmodule

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [7:0]  cpu_wr_data = '0;
    logic [12:0] ppu_addr = '0;
    logic [17:0] prg_addr;
    logic [16:0] chr_addr;
    logic [1:0]  mirror;

    int n_checks = 0;
    int n_errors = 0;

    logic [4:0] m_shift = '0;
    int         m_cnt = 0;
    logic [4:0] m_ctrl = 5'h1C;
    logic [4:0] m_lo = '0;
    logic [4:0] m_hi = '0;
    logic [3:0] m_prg = '0;

    serial_bank_ctrl #(.PRG_BANKS(NB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_addr    (cpu_addr),
        .cpu_wr_data (cpu_wr_data),
        .ppu_addr    (ppu_addr),
        .prg_addr    (prg_addr),
        .chr_addr    (chr_addr),
        .mirror      (mirror)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_prg(input logic [14:0] a);
        int bank;
        int mode = int'(m_ctrl[3:2]);
        int up = int'(a[14]);
        if (mode < 2)       bank = (int'(m_prg) / 2) * 2 + up;
        else if (mode == 2) bank = up ? int'(m_prg) : 0;
        else                bank = up ? NB - 1 : int'(m_prg);
        return bank * 16384 + int'(a[13:0]);
    endfunction

    function automatic int exp_chr(input logic [12:0] p);
        if (m_ctrl[4]) begin
            if (p < 13'h1000) return int'(m_lo) * 4096 + int'(p[11:0]);
            return int'(m_hi) * 4096 + int'(p[11:0]);
        end
        return (int'(m_lo) / 2) * 8192 + int'(p);
    endfunction

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr_en   = 1'b1;
        cpu_addr    = a;
        cpu_wr_data = d;
        @(negedge clk);
        cpu_wr_en   = 1'b0;
        if (d[7]) begin
            m_shift = '0;
            m_cnt   = 0;
            m_ctrl  = m_ctrl | 5'h0C;
        end else begin
            m_shift = {d[0], m_shift[4:1]};
            m_cnt++;
            if (m_cnt == 5) begin
                case (a[14:13])
                    2'd0: m_ctrl = m_shift;
                    2'd1: m_lo   = m_shift;
                    2'd2: m_hi   = m_shift;
                    default: m_prg = m_shift[3:0];
                endcase
                m_shift = '0;
                m_cnt   = 0;
            end
        end
    endtask

    // five writes with noise in the ignored data bits and early addresses
    task automatic load5(input logic [1:0] sel, input logic [4:0] v);
        for (int i = 0; i < 5; i++) begin
            logic [7:0]  d = {1'b0, 6'($urandom), v[i]};
            logic [14:0] a = 15'($urandom);
            if (i == 4) a[14:13] = sel;
            wr(a, d);
        end
    endtask

    task automatic probe(input string tag, input logic [14:0] a, input logic [12:0] p);
        cpu_addr = a;
        ppu_addr = p;
        #1;
        chk(tag, 32'(prg_addr), 32'(exp_prg(a)));
        chk(tag, 32'(chr_addr), 32'(exp_chr(p)));
        chk(tag, 32'(mirror), 32'(m_ctrl[1:0]));
    endtask

    task automatic probe_rand(input string tag, input int n);
        for (int i = 0; i < n; i++) probe(tag, 15'($urandom), 13'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, literal expectations
        cpu_addr = 15'h4123; ppu_addr = 13'h1ABC; #1;
        chk("R1 upper window last bank", 32'(prg_addr), 32'h1C123);
        chk("R1 chr hi bank zero", 32'(chr_addr), 32'h00ABC);
        chk("R1 mirror", 32'(mirror), 32'd0);
        cpu_addr = 15'h0055; #1;
        chk("R1 lower window bank zero", 32'(prg_addr), 32'h00055);

        // R5: every mirroring code
        for (int m = 0; m < 4; m++) begin
            load5(2'd0, {3'b111, 2'(m)});
            #1;
            chk("R5 mirror code", 32'(mirror), 32'(m));
        end

        // R4 and R7: mode 2, bank register 5
        load5(2'd3, 5'h15);
        load5(2'd0, 5'b11001);
        cpu_addr = 15'h4010; #1;
        chk("R7 upper switched", 32'(prg_addr), 32'h14010);
        cpu_addr = 15'h2010; #1;
        chk("R7 lower fixed", 32'(prg_addr), 32'h02010);
        chk("R4 prg keeps bits 3:0", 32'(m_prg), 32'h5);

        // R8: mode 3
        load5(2'd0, 5'b11100);
        cpu_addr = 15'h0001; #1;
        chk("R8 lower switched", 32'(prg_addr), 32'h14001);
        cpu_addr = 15'h7FFF; #1;
        chk("R8 upper last", 32'(prg_addr), 32'h1FFFF);

        // R6: 32 KB mode drops bank bit 0
        load5(2'd0, 5'b10010);
        cpu_addr = 15'h4000; #1;
        chk("R6 32K upper", 32'(prg_addr), 32'h14000);
        cpu_addr = 15'h0000; #1;
        chk("R6 32K lower", 32'(prg_addr), 32'h10000);

        // R9: split character banks
        load5(2'd1, 5'h07);
        load5(2'd2, 5'h1A);
        load5(2'd0, 5'b11110);
        ppu_addr = 13'h0123; #1;
        chk("R9 low 4K", 32'(chr_addr), 32'h07123);
        ppu_addr = 13'h1123; #1;
        chk("R9 high 4K", 32'(chr_addr), 32'h1A123);

        // R10: single 8 KB bank ignores bit 0 and the high register
        load5(2'd0, 5'b01110);
        ppu_addr = 13'h1123; #1;
        chk("R10 8K high half", 32'(chr_addr), 32'h07123);
        ppu_addr = 13'h0004; #1;
        chk("R10 8K low half", 32'(chr_addr), 32'h06004);

        // R2: restart bit collides with a pending fifth write
        load5(2'd0, 5'b01001);
        for (int i = 0; i < 4; i++) wr(15'h6000, 8'h01);
        wr(15'h6000, 8'hFF);
        probe("R2 restart at fifth write", 15'h0000, 13'h0000);
        probe("R2 restart at fifth write", 15'h4321, 13'h1777);
        cpu_addr = 15'h4000; #1;
        chk("R2 forced mode 3", 32'(prg_addr[17:14]), 32'(NB - 1));
        chk("R2 mirror kept", 32'(mirror), 32'd1);
        load5(2'd3, 5'h02);
        cpu_addr = 15'h0000; #1;
        chk("R2 count restarted", 32'(prg_addr), 32'h08000);

        // R3: serial assembly, LSB first, noisy upper bits
        load5(2'd1, 5'b10110);
        probe("R3 serial order", 15'h0000, 13'h0FFF);

        // random traffic, restart bit about one write in eight
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d = 8'($urandom);
            d[7] = ($urandom % 8 == 0);
            wr(15'($urandom), d);
            probe("R3 R4 random", 15'($urandom), 13'($urandom));
        end
        probe_rand("R6 R7 R8 R9 R10 random", 20);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule